// File: doc/BRIEF.md
# Credit-Based Pipelined Flit Link

This block carries fixed-width flits from a producer to a consumer over a link whose forward direction is cut by a configurable number of register stages. Flow control runs on credits rather than on a ready signal that crosses the whole link in one cycle. Credits travel back to the sender through their own configurable chain of register stages, so neither direction has a long combinational path. The sender starts with one credit for every slot of the receive buffer. Each accepted flit costs one credit, and each credit that comes back adds one.

The producer side is a valid/ready input, and the consumer side is a valid/ready output. The receive buffer holds `FWD_STAGES + BWD_STAGES` flits, which is enough to absorb everything that can be in flight during one round trip. The sender has a small state machine with three named states:

- `CS_FULL`: every credit is at hand.
- `CS_PARTIAL`: some credits are out.
- `CS_STARVED`: no credit is left.

The state moves on four transitions:

- `T_SPEND`: a flit is sent with no credit returning.
- `T_REFUND`: a credit returns with no flit sent.
- `T_SWAP`: both happen in the same cycle.
- `T_HOLD`: neither happens.

A `T_SPEND` from one credit enters `CS_STARVED`. A `T_REFUND` from `CS_STARVED` leaves it. A `T_REFUND` that restores the last credit enters `CS_FULL`. `T_SWAP` and `T_HOLD` keep the state.

Top module: `credit_link`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A flit accepted on the input while the buffer is empty and `out_ready` is 0 raises `out_valid` exactly `FWD_STAGES` clock edges after the accepting edge, carrying the same data.
- R3: The credit counter resets to `FWD_STAGES + BWD_STAGES`, and `in_ready` is 1 exactly when it is nonzero. With no flit consumed, exactly `FWD_STAGES + BWD_STAGES` flits are accepted, and then `in_ready` goes to 0.
- R4: While no credit is held and none returns, `in_valid` has no effect: `in_ready` stays 0 and no further flit reaches the output.
- R5: Each output handshake returns one credit. When the sender has no credits, `in_ready` rises exactly `BWD_STAGES` edges after the consuming edge.
- R6: A send and a credit return in the same cycle leave the count unchanged. After any traffic has fully drained, exactly `FWD_STAGES + BWD_STAGES` flits are again accepted before `in_ready` drops.
- R7: Flits leave in the order they were accepted, with none lost and none duplicated, under any backpressure pattern.
- R8: The receive buffer never gets a write while it holds `FWD_STAGES + BWD_STAGES` flits.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` does not change on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a flit |
| in_ready | output | 1 | Sender holds at least one credit |
| in_data | input | DATA_W | Offered flit |
| out_valid | output | 1 | Receive buffer has a flit |
| out_ready | input | 1 | Consumer takes the flit |
| out_data | output | DATA_W | Oldest buffered flit |

## Verification
The bench drains the credits to zero with the consumer stalled. A counter that starts one too high would accept an extra flit and overflow the buffer; one that starts too low would stall early. It then measures the exact edges from a single consume to the return of `in_ready`, which catches a credit pipe that is too short or too long. It also measures the edges from accept to `out_valid`, which catches a forward pipe of the wrong length. Several backpressure sweeps compare every output flit against a sequence number, which exposes lost or reordered flits and any mishandled simultaneous spend and refund. After each sweep the bench recounts the credits, so a single leaked credit shows up.

// File: rtl/cl_pkg.sv
package cl_pkg;
    typedef enum logic [1:0] {
        CS_FULL    = 2'd0,
        CS_PARTIAL = 2'd1,
        CS_STARVED = 2'd2
    } credit_state_e;

    typedef enum logic [1:0] {
        T_HOLD   = 2'd0,
        T_SPEND  = 2'd1,
        T_REFUND = 2'd2,
        T_SWAP   = 2'd3
    } credit_move_e;
endpackage

// File: rtl/cl_pipe.sv
module cl_pipe #(
    parameter int W     = 8,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] d_o
);
    generate
        if (DEPTH == 0) begin : g_wire
            assign d_o = d_i;
        end else begin : g_regs
            logic [W-1:0] stg [DEPTH];
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
                end else begin
                    stg[0] <= d_i;
                    for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
                end
            end
            assign d_o = stg[DEPTH-1];
        end
    endgenerate
endmodule

// File: rtl/cl_sender.sv
module cl_sender
    import cl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic            in_ready,
    input  logic            credit_i,
    output logic [DATA_W:0] fwd_o
);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SLOTS);

    credit_state_e    state_q, state_d;
    credit_move_e     move;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             send;

    assign send = in_valid && in_ready;
    assign move = credit_move_e'({credit_i, send});

    always_comb begin
        unique case (move)
            T_SPEND:  cnt_d = cnt_q - CNT_W'(1);
            T_REFUND: cnt_d = cnt_q + CNT_W'(1);
            T_SWAP:   cnt_d = cnt_q;
            default:  cnt_d = cnt_q;
        endcase
        if (cnt_d == '0)           state_d = CS_STARVED;
        else if (cnt_d == CNT_TOP) state_d = CS_FULL;
        else                       state_d = CS_PARTIAL;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_FULL;
            cnt_q   <= CNT_TOP;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CS_FULL:    in_ready = 1'b1;
            CS_PARTIAL: in_ready = 1'b1;
            CS_STARVED: in_ready = 1'b0;
            default:    in_ready = 1'b0;
        endcase
    end

    assign fwd_o = send ? {1'b1, in_data} : '0;

    a_r3_ready_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0) |-> !in_ready);
    a_r4_dry_stays_dry: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !credit_i) |=> (cnt_q == '0));
    a_r5_refund_adds: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_i && !send) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
    a_r6_swap_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_i && send) |=> $stable(cnt_q));
    a_r8_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_TOP);
endmodule

// File: rtl/cl_rx_buf.sv
module cl_rx_buf #(
    parameter int DATA_W = 8,
    parameter int SLOTS  = 4,
    parameter int CNT_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DATA_W:0] fwd_i,
    output logic            out_valid,
    input  logic            out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic            credit_o
);
    localparam int PTR_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(SLOTS - 1);

    logic [DATA_W-1:0] mem [SLOTS];
    logic [PTR_W-1:0]  wr_q, rd_q;
    logic [CNT_W-1:0]  fill_q;
    logic              push, pop;

    assign push      = fwd_i[DATA_W];
    assign out_valid = (fill_q != '0);
    assign pop       = out_valid && out_ready;
    assign out_data  = mem[rd_q];
    assign credit_o  = pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q   <= '0;
            rd_q   <= '0;
            fill_q <= '0;
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else begin
            if (push) begin
                mem[wr_q] <= fwd_i[DATA_W-1:0];
                wr_q      <= (wr_q == PTR_LAST) ? '0 : wr_q + PTR_W'(1);
            end
            if (pop) rd_q <= (rd_q == PTR_LAST) ? '0 : rd_q + PTR_W'(1);
            if (push && !pop)      fill_q <= fill_q + CNT_W'(1);
            else if (pop && !push) fill_q <= fill_q - CNT_W'(1);
        end
    end

    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill_q < CNT_W'(SLOTS)) || pop);
    a_r9_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int DATA_W     = 8,
    parameter int FWD_STAGES = 3,
    parameter int BWD_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    localparam int SLOTS = FWD_STAGES + BWD_STAGES;
    localparam int CNT_W = $clog2(SLOTS + 1);

    logic [DATA_W:0] fwd_near, fwd_far;
    logic [0:0]      cred_near, cred_far;

    cl_sender #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_send (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .credit_i(cred_far[0]), .fwd_o(fwd_near));

    cl_pipe #(.W(DATA_W + 1), .DEPTH(FWD_STAGES)) u_fwd (
        .clk(clk), .rst_n(rst_n), .d_i(fwd_near), .d_o(fwd_far));

    cl_rx_buf #(.DATA_W(DATA_W), .SLOTS(SLOTS), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .fwd_i(fwd_far), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .credit_o(cred_near[0]));

    cl_pipe #(.W(1), .DEPTH(BWD_STAGES)) u_bwd (
        .clk(clk), .rst_n(rst_n), .d_i(cred_near), .d_o(cred_far));

    a_r1_reset_state: assert property (@(posedge clk)
        $rose(rst_n) |-> (in_ready && !out_valid));
endmodule

// File: tb/credit_link_tb_top.sv
module credit_link_tb_top;
    localparam int DW = 8;
    localparam int LF = 3;
    localparam int LB = 2;
    localparam int SL = LF + LB;
    localparam int NFLIT = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
    logic [DW-1:0] in_data = '0, out_data;
    int checks = 0, errors = 0;
    logic [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    credit_link #(.DATA_W(DW), .FWD_STAGES(LF), .BWD_STAGES(LB)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    task automatic do_reset();
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        step();
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    endtask

    // stalled consumer: count how many flits are accepted (R3 / R6)
    task automatic count_credits(input string req, output int acc);
        acc = 0;
        out_ready = 1'b0;
        for (int c = 0; c < SL + 6; c++) begin
            in_valid = 1'b1;
            in_data  = DW'(8'h80 + acc);
            if (in_ready) acc++;
            step();
        end
        in_valid = 1'b0;
        chk(acc == SL, req, acc, SL);
        chk(in_ready == 1'b0, {req, " ready low"}, int'(in_ready), 0);
    endtask

    // drain everything, verify order of the credit-count flits, let credits return
    task automatic drain_counted(input int n);
        int got = 0;
        out_ready = 1'b1;
        for (int c = 0; c < 3 * SL + 10; c++) begin
            if (out_valid) begin
                chk(out_data == DW'(8'h80 + got), "R7 drain order", int'(out_data), 8'h80 + got);
                got++;
            end
            step();
        end
        out_ready = 1'b0;
        chk(got == n, "R7 drain count", got, n);
    endtask

    initial begin
        int acc;
        do_reset();

        // R2: forward latency
        in_valid = 1'b1; in_data = 8'hA5;
        step();
        in_valid = 1'b0;
        for (int k = 1; k <= LF; k++) begin
            step();
            chk(out_valid == (k == LF), "R2 latency", int'(out_valid), int'(k == LF));
        end
        chk(out_data == 8'hA5, "R2 data", int'(out_data), 8'hA5);

        // R3: exhaust credits (one already spent)
        acc = 1;
        for (int c = 0; c < SL + 6; c++) begin
            in_valid = 1'b1; in_data = DW'(c);
            if (in_ready) acc++;
            step();
        end
        chk(acc == SL, "R3 credit total", acc, SL);
        // R4 / R9: stall while dry, in_valid held high
        for (int c = 0; c < 8; c++) begin
            step();
            chk(in_ready == 1'b0, "R4 dry ready", int'(in_ready), 0);
            chk(out_valid && out_data == 8'hA5, "R9 held output", int'(out_data), 8'hA5);
        end
        in_valid = 1'b0;

        // R5: one consume, credit returns after LB edges
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        for (int k = 1; k <= LB + 2; k++) begin
            chk(in_ready == (k > LB), "R5 credit return", int'(in_ready), int'(k > LB));
            step();
        end

        // R7 / R8 / R6: backpressure sweeps with scoreboard
        for (int mode = 0; mode < 5; mode++) begin
            int tx = 0, rx = 0, guard = 0;
            bit held = 1'b0;
            logic [DW-1:0] hd = '0;
            do_reset();
            while (rx < NFLIT && guard < 4000) begin
                if (held)
                    chk(out_valid && out_data == hd, "R9 stall hold", int'(out_data), int'(hd));
                in_valid = (tx < NFLIT) && ((mode == 4) ? 1'b1 : lf[3]);
                in_data  = DW'(tx) ^ 8'h3C;
                case (mode)
                    0: out_ready = 1'b1;
                    1: out_ready = guard[0];
                    2: out_ready = lf[7];
                    3: out_ready = lf[5] & lf[9];
                    default: out_ready = lf[11] | lf[2];
                endcase
                held = out_valid && !out_ready;
                hd   = out_data;
                if (in_valid && in_ready) tx++;
                if (out_valid && out_ready) begin
                    // R8: an overflow would drop a flit and break this sequence
                    chk(out_data == (DW'(rx) ^ 8'h3C), "R7 order", int'(out_data), int'(DW'(rx) ^ 8'h3C));
                    rx++;
                end
                guard++;
                step();
            end
            in_valid = 1'b0; out_ready = 1'b0;
            chk(rx == NFLIT, "R7 all delivered", rx, NFLIT);
            repeat (LB + 3) step();
            chk(out_valid == 1'b0, "R7 no duplicate", int'(out_valid), 0);
            count_credits("R6 credits conserved", acc);
            drain_counted(SL);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule